// File: doc/BRIEF.md
# Sequencer Code Interpreter

This block runs a small program of 32-bit instruction words held in its own program memory. Software fills the memory through a word-wide write port. A start command then launches execution at address 0. Each play instruction hands a (pattern number, repetition count) pair to a downstream pattern player by writing it into that player's FIFO. The program can wrap pattern plays in counted loops, in endless loops and in subroutine calls, and these nest. Execution ends in one of three ways: a halt instruction, an external stop command, or a fault. A fault is a stack overflow, a stack underflow or a reserved opcode. Three status outputs show whether the interpreter is running, finished cleanly, or faulted.

The instruction word has a 3-bit opcode in bits [31:29], operand A in bits [28:16] and operand B in bits [15:0]. Loop bookkeeping lives in a loop stack. Each entry holds the body start address, the remaining count and an endless flag. Return addresses live in a separate call stack. The depth of each stack is a parameter, 8 by default. The interpreter runs at 100 MHz in the target system.

The control is one state machine:
- **Idle** is the state after reset.
- **Fetch** waits out the one-cycle memory read.
- **Exec** acts on the word.
- **Scan-fetch** and **Scan** walk forward over the body of a zero-count loop.
- **Done** is clean termination.
- **Fault** is error termination.

Transitions:
- A start moves Idle, Done or Fault to Fetch, with both stacks cleared.
- Fetch always goes to Exec.
- Exec goes:
  - back to Fetch after a normal instruction;
  - to Scan-fetch on a zero loop count;
  - to Done on a halt;
  - to Fault on an error.
  - Exec stays in Exec while the FIFO is full.
- Scan-fetch goes to Scan.
- Scan returns to Scan-fetch until the matching loop end, then to Fetch.
- A stop moves any of Fetch, Exec, Scan-fetch and Scan to Done.

Top module: `seq_interp`

## Requirements
- R1: After reset the status outputs running, done and error are all 0, and no FIFO write occurs.
- R2: Opcode 001 writes one FIFO entry, with pattern = operand A (13 bits) and repetitions = operand B (16 bits). Entries appear in program order. Opcode 000 ends the run with done = 1 and running = 0. Words written through the program port are the words executed.
- R3: Opcode 010 opens a loop whose count is operand B. The body, which ends at the matching opcode 011, runs exactly that many times. Loops nest, and a count of 1 runs the body once.
- R4: A loop with count 0 skips its body, including any nested loops inside it. Execution continues after its matching 011.
- R5: Opcode 100 opens a loop that repeats until the stop command. A stop ends any running program with done = 1 and running = 0. No FIFO write occurs in the cycle the stop is high or afterwards.
- R6: Opcode 101 calls the subroutine at address operand A. Opcode 110 resumes at the word after the most recent call, and calls nest.
- R7: While the FIFO full input is high, no FIFO write occurs and execution waits. No entry is lost or repeated.
- R8: A ninth nested loop or a ninth nested call (stack depth 8) ends the run with error = 1 and done = 0. The error state holds until the next start.
- R9: Opcode 011 with no open loop, or opcode 110 with no pending call, ends the run with error = 1.
- R10: Opcode 111 ends the run with error = 1, after the entries of the instructions before it have been written.
- R11: A start from the done or error state begins again at address 0 with both stacks empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | PC_W | Program memory write address |
| prog_wdata | input | 32 | Instruction word to store |
| start_cmd | input | 1 | Start execution at address 0 (ignored while running) |
| stop_cmd | input | 1 | Stop execution |
| fifo_full | input | 1 | Pattern FIFO cannot accept an entry |
| fifo_push | output | 1 | Pattern FIFO write strobe |
| fifo_pattern | output | 13 | Pattern number of the entry |
| fifo_reps | output | 16 | Repetition count of the entry |
| status_run | output | 1 | Program is executing |
| status_done | output | 1 | Program ended by halt or stop |
| status_err | output | 1 | Program ended by a fault |

## Verification
The hardest cases to reach are the two stack faults and the stack clearing on restart. The bench builds them from tiny programs:
- A self-call at address 0 exhausts the call stack.
- Nine back-to-back loop openers exhaust the loop stack.
- After that fault, a program with eight nested single-pass loops must finish cleanly. It can do so only if the restart emptied the leftover entries.

Zero-count skipping is driven with a skipped body that itself holds a counted loop and an endless loop, so the nesting scan is exercised. The stop command is timed against a running endless loop by watching the scoreboard queue drain.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int INSTR_W = 32;
    localparam int OPA_W   = 13;
    localparam int OPB_W   = 16;
    localparam int OPC_LSB = 29;

    typedef enum logic [2:0] {
        OP_HALT     = 3'd0,
        OP_PLAY     = 3'd1,
        OP_LOOP     = 3'd2,
        OP_LEND     = 3'd3,
        OP_LFOREVER = 3'd4,
        OP_CALL     = 3'd5,
        OP_RET      = 3'd6,
        OP_RSVD     = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_SCAN_FETCH,
        ST_SCAN,
        ST_DONE,
        ST_FAULT
    } state_e;

endpackage

// File: rtl/seq_prog_ram.sv
module seq_prog_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic         repl,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_m1;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;

    always_comb begin
        cnt_m1  = cnt - 1'b1;
        top_idx = cnt_m1[IW-1:0];
        wr_idx  = cnt[IW-1:0];
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        top     = mem[top_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= din;
        end else if (repl) begin
            mem[top_idx] <= din;
        end
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R8
    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || repl) |-> !empty);  // R9
    AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop, repl}));  // R3
endmodule

// File: rtl/seq_interp.sv
module seq_interp
    import seq_pkg::*;
#(
    parameter int PC_W       = 8,
    parameter int LOOP_DEPTH = 8,
    parameter int CALL_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic               fifo_full,
    output logic               fifo_push,
    output logic [OPA_W-1:0]   fifo_pattern,
    output logic [OPB_W-1:0]   fifo_reps,
    output logic               status_run,
    output logic               status_done,
    output logic               status_err
);
    localparam int CNT_W  = OPB_W;
    localparam int LENT_W = 1 + CNT_W + PC_W;
    localparam int SCAN_W = PC_W + 1;

    state_e state, state_n;

    logic [PC_W-1:0]    pc, pc_n, pc_inc;
    logic [SCAN_W-1:0]  depth, depth_n;
    logic [INSTR_W-1:0] instr;
    opcode_e            op;
    logic [OPA_W-1:0]   opa;
    logic [OPB_W-1:0]   opb;
    logic               play;
    logic               stk_clr;

    logic              l_push, l_pop, l_repl, l_empty, l_full;
    logic [LENT_W-1:0] l_din, l_top;
    logic              l_top_inf;
    logic [CNT_W-1:0]  l_top_cnt;
    logic [PC_W-1:0]   l_top_pc;

    logic            c_push, c_pop, c_empty, c_full;
    logic [PC_W-1:0] c_din, c_top;

    seq_prog_ram #(.AW(PC_W), .DW(INSTR_W)) u_ram (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_wdata),
        .raddr (pc),
        .rdata (instr)
    );

    seq_stack #(.W(LENT_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stk_clr),
        .push  (l_push),
        .pop   (l_pop),
        .repl  (l_repl),
        .din   (l_din),
        .top   (l_top),
        .empty (l_empty),
        .full  (l_full)
    );

    seq_stack #(.W(PC_W), .DEPTH(CALL_DEPTH)) u_call_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stk_clr),
        .push  (c_push),
        .pop   (c_pop),
        .repl  (1'b0),
        .din   (c_din),
        .top   (c_top),
        .empty (c_empty),
        .full  (c_full)
    );

    // Field extraction and loop-entry unpacking
    always_comb begin
        op        = opcode_e'(instr[INSTR_W-1:OPC_LSB]);
        opa       = instr[OPC_LSB-1:OPB_W];
        opb       = instr[OPB_W-1:0];
        pc_inc    = pc + 1'b1;
        l_top_inf = l_top[LENT_W-1];
        l_top_cnt = l_top[PC_W +: CNT_W];
        l_top_pc  = l_top[PC_W-1:0];
    end

    // Next-state and datapath control
    always_comb begin
        state_n = state;
        pc_n    = pc;
        depth_n = depth;
        play    = 1'b0;
        stk_clr = 1'b0;
        l_push  = 1'b0;
        l_pop   = 1'b0;
        l_repl  = 1'b0;
        l_din   = '0;
        c_push  = 1'b0;
        c_pop   = 1'b0;
        c_din   = '0;

        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (start_cmd) begin
                    state_n = ST_FETCH;
                    pc_n    = '0;
                    stk_clr = 1'b1;
                end
            end

            ST_FETCH: begin
                state_n = stop_cmd ? ST_DONE : ST_EXEC;
            end

            ST_EXEC: begin
                if (stop_cmd) begin
                    state_n = ST_DONE;
                end else begin
                    unique case (op)
                        OP_HALT: begin
                            state_n = ST_DONE;
                        end
                        OP_PLAY: begin
                            if (!fifo_full) begin
                                play    = 1'b1;
                                pc_n    = pc_inc;
                                state_n = ST_FETCH;
                            end
                        end
                        OP_LOOP: begin
                            if (opb == '0) begin
                                depth_n = '0;
                                pc_n    = pc_inc;
                                state_n = ST_SCAN_FETCH;
                            end else if (l_full) begin
                                state_n = ST_FAULT;
                            end else begin
                                l_push  = 1'b1;
                                l_din   = {1'b0, opb, pc_inc};
                                pc_n    = pc_inc;
                                state_n = ST_FETCH;
                            end
                        end
                        OP_LFOREVER: begin
                            if (l_full) begin
                                state_n = ST_FAULT;
                            end else begin
                                l_push  = 1'b1;
                                l_din   = {1'b1, {CNT_W{1'b0}}, pc_inc};
                                pc_n    = pc_inc;
                                state_n = ST_FETCH;
                            end
                        end
                        OP_LEND: begin
                            if (l_empty) begin
                                state_n = ST_FAULT;
                            end else begin
                                state_n = ST_FETCH;
                                if (l_top_inf) begin
                                    pc_n = l_top_pc;
                                end else if (l_top_cnt > CNT_W'(1)) begin
                                    l_repl = 1'b1;
                                    l_din  = {1'b0, l_top_cnt - 1'b1, l_top_pc};
                                    pc_n   = l_top_pc;
                                end else begin
                                    l_pop = 1'b1;
                                    pc_n  = pc_inc;
                                end
                            end
                        end
                        OP_CALL: begin
                            if (c_full) begin
                                state_n = ST_FAULT;
                            end else begin
                                c_push  = 1'b1;
                                c_din   = pc_inc;
                                pc_n    = PC_W'(opa);
                                state_n = ST_FETCH;
                            end
                        end
                        OP_RET: begin
                            if (c_empty) begin
                                state_n = ST_FAULT;
                            end else begin
                                c_pop   = 1'b1;
                                pc_n    = c_top;
                                state_n = ST_FETCH;
                            end
                        end
                        OP_RSVD: begin
                            state_n = ST_FAULT;
                        end
                    endcase
                end
            end

            ST_SCAN_FETCH: begin
                state_n = stop_cmd ? ST_DONE : ST_SCAN;
            end

            ST_SCAN: begin
                if (stop_cmd) begin
                    state_n = ST_DONE;
                end else begin
                    pc_n    = pc_inc;
                    state_n = ST_SCAN_FETCH;
                    if (op == OP_LOOP || op == OP_LFOREVER) begin
                        depth_n = depth + 1'b1;
                    end else if (op == OP_LEND) begin
                        if (depth == '0) begin
                            state_n = ST_FETCH;
                        end else begin
                            depth_n = depth - 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Program counter and scan depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            depth <= '0;
        end else begin
            pc    <= pc_n;
            depth <= depth_n;
        end
    end

    // Outputs
    always_comb begin
        status_run   = (state == ST_FETCH) || (state == ST_EXEC) ||
                       (state == ST_SCAN_FETCH) || (state == ST_SCAN);
        status_done  = (state == ST_DONE);
        status_err   = (state == ST_FAULT);
        fifo_push    = play;
        fifo_pattern = opa;
        fifo_reps    = opb;
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);  // R7
    AST_STOP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |-> !fifo_push);  // R5
    AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && status_run) |=> (status_done && !status_run));  // R5
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_err && !start_cmd) |=> status_err);  // R8
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_run, status_done, status_err}));  // R1
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !status_run) |=> (status_run && !stop_cmd) || $past(stop_cmd) || stop_cmd || status_run);  // R11
endmodule

// File: tb/sim_seq_interp.sv
`timescale 1ns/1ps
module sim_seq_interp;
    localparam int PC_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [PC_W-1:0] prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_push;
    logic [12:0] fifo_pattern;
    logic [15:0] fifo_reps;
    logic        status_run, status_done, status_err;

    always #2.5 clk = ~clk;

    seq_interp #(.PC_W(PC_W), .LOOP_DEPTH(8), .CALL_DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_pattern(fifo_pattern),
        .fifo_reps(fifo_reps), .status_run(status_run), .status_done(status_done),
        .status_err(status_err)
    );

    logic [28:0] expq[$];
    string cur_req = "R1";
    int n_cmp = 0;
    int n_bad = 0;
    int n_push = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(logic [2:0] op, logic [12:0] a, logic [15:0] b);
        return {op, a, b};
    endfunction

    task automatic expect_entry(logic [12:0] p, logic [15:0] r);
        expq.push_back({p, r});
    endtask

    // Monitor: pops the scoreboard on each FIFO write
    always @(negedge clk) begin
        logic [28:0] e;
        if (rst_n && fifo_push) begin
            n_push++;
            if (fifo_full) chk("R7", "write while full", 32'd1, 32'd0);
            if (expq.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s: unexpected entry got %0h expected none", cur_req, {fifo_pattern, fifo_reps});
            end else begin
                e = expq.pop_front();
                chk(cur_req, "fifo entry", {3'b0, fifo_pattern, fifo_reps}, {3'b0, e});
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        prog_we = 1'b1;
        prog_addr = PC_W'(a);
        prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic start_prog(string req);
        cur_req = req;
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic wait_end(string req, bit exp_err);
        int cyc = 0;
        while (status_run && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "running cleared", {31'b0, status_run}, 32'd0);
        chk(req, "done flag", {31'b0, status_done}, {31'b0, !exp_err});
        chk(req, "error flag", {31'b0, status_err}, {31'b0, exp_err});
        chk(req, "entries outstanding", expq.size(), 32'd0);
        expq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p0;
        int cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "run", {31'b0, status_run}, 0);
        chk("R1", "done", {31'b0, status_done}, 0);
        chk("R1", "err", {31'b0, status_err}, 0);
        chk("R1", "push", {31'b0, fifo_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: plain plays then halt
        wr(0, ins(3'd1, 13'd100, 16'd7));
        wr(1, ins(3'd1, 13'd8191, 16'hFFFF));
        wr(2, ins(3'd0, 0, 0));
        expect_entry(100, 7);
        expect_entry(8191, 16'hFFFF);
        start_prog("R2");
        wait_end("R2", 1'b0);

        // R3: nested counted loops, count 1 loop
        wr(0, ins(3'd2, 0, 16'd3));
        wr(1, ins(3'd1, 13'd1, 16'd0));
        wr(2, ins(3'd2, 0, 16'd2));
        wr(3, ins(3'd1, 13'd2, 16'd1));
        wr(4, ins(3'd3, 0, 0));
        wr(5, ins(3'd3, 0, 0));
        wr(6, ins(3'd2, 0, 16'd1));
        wr(7, ins(3'd1, 13'd3, 16'd3));
        wr(8, ins(3'd3, 0, 0));
        wr(9, ins(3'd0, 0, 0));
        for (int i = 0; i < 3; i++) begin
            expect_entry(1, 0);
            expect_entry(2, 1);
            expect_entry(2, 1);
        end
        expect_entry(3, 3);
        start_prog("R3");
        wait_end("R3", 1'b0);

        // R4: zero-count loop skips nested body
        wr(0, ins(3'd1, 13'd10, 16'd0));
        wr(1, ins(3'd2, 0, 16'd0));
        wr(2, ins(3'd1, 13'd11, 16'd0));
        wr(3, ins(3'd2, 0, 16'd2));
        wr(4, ins(3'd1, 13'd12, 16'd0));
        wr(5, ins(3'd3, 0, 0));
        wr(6, ins(3'd4, 0, 0));
        wr(7, ins(3'd3, 0, 0));
        wr(8, ins(3'd3, 0, 0));
        wr(9, ins(3'd1, 13'd13, 16'd0));
        wr(10, ins(3'd0, 0, 0));
        expect_entry(10, 0);
        expect_entry(13, 0);
        start_prog("R4");
        wait_end("R4", 1'b0);

        // R6: nested subroutine calls
        wr(0, ins(3'd5, 13'd10, 0));
        wr(1, ins(3'd1, 13'd20, 16'd0));
        wr(2, ins(3'd5, 13'd10, 0));
        wr(3, ins(3'd0, 0, 0));
        wr(10, ins(3'd1, 13'd21, 16'd0));
        wr(11, ins(3'd5, 13'd20, 0));
        wr(12, ins(3'd6, 0, 0));
        wr(20, ins(3'd1, 13'd22, 16'd0));
        wr(21, ins(3'd6, 0, 0));
        expect_entry(21, 0);
        expect_entry(22, 0);
        expect_entry(20, 0);
        expect_entry(21, 0);
        expect_entry(22, 0);
        start_prog("R6");
        wait_end("R6", 1'b0);

        // R7: stall while FIFO full
        wr(0, ins(3'd1, 13'd1, 16'd1));
        wr(1, ins(3'd1, 13'd2, 16'd2));
        wr(2, ins(3'd1, 13'd3, 16'd3));
        wr(3, ins(3'd0, 0, 0));
        expect_entry(1, 1);
        expect_entry(2, 2);
        expect_entry(3, 3);
        fifo_full = 1'b1;
        p0 = n_push;
        start_prog("R7");
        repeat (30) @(negedge clk);
        chk("R7", "writes while full", n_push - p0, 0);
        chk("R7", "still running", {31'b0, status_run}, 1);
        fifo_full = 1'b0;
        repeat (3) @(negedge clk);
        fifo_full = 1'b1;
        repeat (10) @(negedge clk);
        fifo_full = 1'b0;
        wait_end("R7", 1'b0);
        chk("R7", "total writes", n_push - p0, 3);

        // R5: endless loop ended by stop
        wr(0, ins(3'd4, 0, 0));
        wr(1, ins(3'd1, 13'd5, 16'd9));
        wr(2, ins(3'd3, 0, 0));
        wr(3, ins(3'd0, 0, 0));
        for (int i = 0; i < 30; i++) expect_entry(5, 9);
        p0 = n_push;
        start_prog("R5");
        cyc = 0;
        while (expq.size() > 25 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        expq.delete();
        chk("R5", "done after stop", {31'b0, status_done}, 1);
        chk("R5", "run after stop", {31'b0, status_run}, 0);
        chk("R5", "loop repeated", {31'b0, (n_push - p0) >= 5}, 1);
        p0 = n_push;
        repeat (20) @(negedge clk);
        chk("R5", "writes after stop", n_push - p0, 0);
        chk("R5", "done holds", {31'b0, status_done}, 1);

        // R8: call stack overflow via self call
        wr(0, ins(3'd5, 13'd0, 0));
        start_prog("R8");
        wait_end("R8", 1'b1);
        repeat (5) @(negedge clk);
        chk("R8", "error holds", {31'b0, status_err}, 1);

        // R8: loop stack overflow, one play first
        wr(0, ins(3'd1, 13'd4, 16'd4));
        for (int i = 1; i <= 9; i++) wr(i, ins(3'd2, 0, 16'd1));
        wr(10, ins(3'd0, 0, 0));
        expect_entry(4, 4);
        start_prog("R8");
        wait_end("R8", 1'b1);

        // R11: restart clears the full loop stack
        for (int i = 0; i < 8; i++) wr(i, ins(3'd2, 0, 16'd1));
        wr(8, ins(3'd1, 13'd7, 16'd7));
        for (int i = 9; i < 17; i++) wr(i, ins(3'd3, 0, 0));
        wr(17, ins(3'd0, 0, 0));
        expect_entry(7, 7);
        start_prog("R11");
        wait_end("R11", 1'b0);

        // R9: loop end and return with empty stacks
        wr(0, ins(3'd3, 0, 0));
        start_prog("R9");
        wait_end("R9", 1'b1);
        wr(0, ins(3'd6, 0, 0));
        start_prog("R9");
        wait_end("R9", 1'b1);

        // R10: reserved opcode
        wr(0, ins(3'd1, 13'd1, 16'd1));
        wr(1, ins(3'd7, 0, 0));
        expect_entry(1, 1);
        start_prog("R10");
        wait_end("R10", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule